// File: doc/BRIEF.md
# Windowed Service Watchdog with Fail Counter

This block supervises a host processor by requiring it to service the watchdog at the right time. Time is counted in ticks of a slow tick enable. Each watchdog sequence starts with a closed window, in which servicing is not allowed, and continues with an open window, in which the host must service. A service pulse inside the open window is a good event. A service inside the closed window is a bad event. An open window that ends with no service is also a bad event. A saturating 3-bit fail counter rises on bad events and falls on good events.

The fail counter always runs, whatever the setting of the reset-enable input. Software can read the counter but can never write it. After power-on, and each time the device enters its diagnostic state, the counter starts at 5. When the counter already sits at 7 and reset is enabled, a further bad event makes the block issue a one-cycle reset request. Setting reset-enable while the counter is at 7 also issues the request, without waiting for another bad event. Both window lengths are held in local configuration registers. A watchdog-issued reset does not change them. Only the power-on reset returns them to their defaults.

Top module: `wdt_window_guard`

## Requirements
- R1: After power-on reset, fail_cnt reads 5 and reset_req is 0. The closed-window length field is 0x7F and the open-window length field is 0x1F.
- R2: The closed window lasts max(C,1) ticks, where C is the 7-bit closed-length field. A service in the closed window is a bad event that adds 1 to fail_cnt, with saturation at 7.
- R3: The open window lasts O+1 ticks, where O is the 5-bit open-length field. A service in the open window is a good event: it subtracts 1 from fail_cnt (floor 0) and starts a new closed window at once.
- R4: If the open window's last tick arrives with no service, that tick is a bad event (+1, saturating) and a new closed window starts.
- R5: fail_cnt counts up and down in the same way whether rst_en is 0 or 1. It never rises above 7 and never falls below 0.
- R6: A bad event while fail_cnt is 7 and rst_en is 1 raises reset_req for one clock, in the cycle after the event. With rst_en at 0 the same event raises no request. In both cases fail_cnt stays at 7.
- R7: A 0-to-1 change of rst_en while fail_cnt is 7 raises reset_req in the next cycle. The same change while fail_cnt is below 7 raises no request.
- R8: A reset request restarts the window timer at the first tick of the closed window.
- R9: A diag_entry pulse sets fail_cnt to 5 and restarts the window timer at the closed window. A service or timeout in the same cycle is ignored.
- R10: A cfg_wr pulse loads both length fields. The loaded values survive reset requests and diag_entry. Only rst_n restores the defaults.
- R11: When a service and a tick fall in the same cycle, the service is judged by the window that was in force before that tick. The tick still advances the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_en | input | 1 | One-cycle pulse marking one watchdog time unit |
| svc_strobe | input | 1 | Service pulse from the host |
| cfg_wr | input | 1 | Load pulse for both window length fields |
| cfg_closed_len | input | 7 | New closed-window length in ticks |
| cfg_open_len | input | 5 | New open-window length, in ticks minus one |
| rst_en | input | 1 | Allows reset requests when high |
| diag_entry | input | 1 | Pulse on entry to the diagnostic state |
| fail_cnt | output | 3 | Read-only fail counter value |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A wrong window-timer state appears as a service that is judged the wrong way. fail_cnt then moves by one in the opposite direction on the first clock after that service. It can also appear as a timeout on the wrong tick, where fail_cnt moves one tick early or late. A wrong counter value, or a wrong record of the previous rst_en value, appears at reset_req: the pulse is missing or extra in the cycle after the bad event or the change of rst_en. Configuration corruption changes where the window boundary falls, so the sweep of service positions across each window pins it to a single tick.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  // Phase of the current watchdog sequence
  typedef enum logic {
    WIN_CLOSED = 1'b0,
    WIN_OPEN   = 1'b1
  } win_phase_e;

  // Verdict produced in one clock cycle
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_GOOD = 2'd1,
    EV_BAD  = 2'd2
  } wd_event_e;

endpackage

// File: rtl/wdt_cfg_store.sv
module wdt_cfg_store #(
  parameter int CLOSED_W = 7,
  parameter int OPEN_W   = 5,
  parameter logic [CLOSED_W-1:0] CLOSED_DEF = '1,
  parameter logic [OPEN_W-1:0]   OPEN_DEF   = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CLOSED_W-1:0] closed_in,
  input  logic [OPEN_W-1:0]   open_in,
  output logic [CLOSED_W-1:0] closed_len,
  output logic [OPEN_W-1:0]   open_len
);

  logic [CLOSED_W-1:0] closed_q, closed_d;
  logic [OPEN_W-1:0]   open_q, open_d;

  // Only the power-on reset reaches these flops; watchdog requests do not
  always_comb begin
    closed_d = closed_q;
    open_d   = open_q;
    if (wr_en) begin
      closed_d = closed_in;
      open_d   = open_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      closed_q <= CLOSED_DEF;
      open_q   <= OPEN_DEF;
    end else begin
      closed_q <= closed_d;
      open_q   <= open_d;
    end
  end

  assign closed_len = closed_q;
  assign open_len   = open_q;

endmodule

// File: rtl/wdt_window_seq.sv
module wdt_window_seq
  import wdt_guard_pkg::*;
#(
  parameter int CLOSED_W = 7,
  parameter int OPEN_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                svc_strobe,
  input  logic                restart,
  input  logic [CLOSED_W-1:0] closed_len,
  input  logic [OPEN_W-1:0]   open_len,
  output win_phase_e          phase,
  output wd_event_e           evt
);

  // The tick counter must hold the longer of the two windows
  localparam int CW = (CLOSED_W > OPEN_W + 1) ? CLOSED_W : OPEN_W + 1;
  localparam int EW = CW + 1;

  win_phase_e    phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [EW-1:0] cnt_inc, closed_tgt, open_tgt;
  logic          closed_end, open_end, timeout;

  // Window boundaries; a zero closed length still takes one tick
  always_comb begin
    cnt_inc    = EW'(cnt_q) + EW'(1);
    closed_tgt = EW'(closed_len);
    open_tgt   = EW'(open_len) + EW'(1);
    closed_end = tick_en && (phase_q == WIN_CLOSED) && (cnt_inc >= closed_tgt);
    open_end   = tick_en && (phase_q == WIN_OPEN) && (cnt_inc >= open_tgt);
    timeout    = open_end && !svc_strobe;
  end

  // A service is judged by the phase held before this cycle's tick
  always_comb begin
    evt = EV_NONE;
    if (svc_strobe) begin
      evt = (phase_q == WIN_CLOSED) ? EV_BAD : EV_GOOD;
    end else if (timeout) begin
      evt = EV_BAD;
    end
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (restart || (evt == EV_GOOD) || timeout) begin
      phase_d = WIN_CLOSED;
      cnt_d   = '0;
    end else if (closed_end) begin
      phase_d = WIN_OPEN;
      cnt_d   = '0;
    end else if (tick_en) begin
      cnt_d   = cnt_inc[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= WIN_CLOSED;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/wdt_fail_track.sv
module wdt_fail_track
  import wdt_guard_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int CNT_INIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wd_event_e        evt,
  input  logic             diag_entry,
  input  logic             rst_en,
  output logic [CNT_W-1:0] fail_cnt,
  output logic             req_now,
  output logic             reset_req
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] INIT_V  = CNT_INIT[CNT_W-1:0];

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en_q;
  logic             req_q;
  logic             at_max, en_rise;

  // Request on overflow, or when reset is enabled with the counter already full
  always_comb begin
    at_max  = (cnt_q == CNT_MAX);
    en_rise = rst_en && !en_q;
    req_now = !diag_entry && rst_en && at_max && ((evt == EV_BAD) || en_rise);
  end

  // Counting ignores rst_en; diagnostic entry overrides every event
  always_comb begin
    cnt_d = cnt_q;
    if (diag_entry) begin
      cnt_d = INIT_V;
    end else begin
      unique case (evt)
        EV_BAD:  if (!at_max)       cnt_d = cnt_q + 1'b1;
        EV_GOOD: if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= INIT_V;
      en_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= rst_en;
      req_q <= req_now;
    end
  end

  assign fail_cnt  = cnt_q;
  assign reset_req = req_q;

endmodule

// File: rtl/wdt_window_guard.sv
module wdt_window_guard
  import wdt_guard_pkg::*;
#(
  parameter int CLOSED_W = 7,
  parameter int OPEN_W   = 5,
  parameter int CNT_W    = 3,
  parameter int CNT_INIT = 5,
  parameter logic [CLOSED_W-1:0] CLOSED_DEF = 7'h7F,
  parameter logic [OPEN_W-1:0]   OPEN_DEF   = 5'h1F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                svc_strobe,
  input  logic                cfg_wr,
  input  logic [CLOSED_W-1:0] cfg_closed_len,
  input  logic [OPEN_W-1:0]   cfg_open_len,
  input  logic                rst_en,
  input  logic                diag_entry,
  output logic [CNT_W-1:0]    fail_cnt,
  output logic                reset_req
);

  // Reset is asserted asynchronously and released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [CLOSED_W-1:0] closed_len;
  logic [OPEN_W-1:0]   open_len;
  win_phase_e          win_phase;
  wd_event_e           win_evt;
  logic                req_now;
  logic                tmr_restart;

  assign tmr_restart = diag_entry || req_now;

  wdt_cfg_store #(
    .CLOSED_W  (CLOSED_W),
    .OPEN_W    (OPEN_W),
    .CLOSED_DEF(CLOSED_DEF),
    .OPEN_DEF  (OPEN_DEF)
  ) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (cfg_wr),
    .closed_in (cfg_closed_len),
    .open_in   (cfg_open_len),
    .closed_len(closed_len),
    .open_len  (open_len)
  );

  wdt_window_seq #(
    .CLOSED_W(CLOSED_W),
    .OPEN_W  (OPEN_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick_en   (tick_en),
    .svc_strobe(svc_strobe),
    .restart   (tmr_restart),
    .closed_len(closed_len),
    .open_len  (open_len),
    .phase     (win_phase),
    .evt       (win_evt)
  );

  wdt_fail_track #(
    .CNT_W   (CNT_W),
    .CNT_INIT(CNT_INIT)
  ) trk_i (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .evt       (win_evt),
    .diag_entry(diag_entry),
    .rst_en    (rst_en),
    .fail_cnt  (fail_cnt),
    .req_now   (req_now),
    .reset_req (reset_req)
  );

endmodule

// File: rtl/wdt_window_guard_chk.sv
module wdt_window_guard_chk
  import wdt_guard_pkg::*;
#(
  parameter int CLOSED_W = 7,
  parameter int OPEN_W   = 5,
  parameter int CNT_W    = 3,
  parameter int CNT_INIT = 5
) (
  input logic                clk,
  input logic                rst_n_s,
  input logic                svc_strobe,
  input logic                diag_entry,
  input logic                rst_en,
  input logic                cfg_wr,
  input win_phase_e          win_phase,
  input logic [CLOSED_W-1:0] closed_len,
  input logic [OPEN_W-1:0]   open_len,
  input logic [CNT_W-1:0]    fail_cnt,
  input logic                reset_req
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] INIT_V  = CNT_INIT[CNT_W-1:0];

  // R2
  closed_bad_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (svc_strobe && win_phase == WIN_CLOSED && !diag_entry && fail_cnt != CNT_MAX)
      |=> fail_cnt == $past(fail_cnt) + 1'b1);

  // R3
  open_good_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (svc_strobe && win_phase == WIN_OPEN && !diag_entry && fail_cnt != '0)
      |=> fail_cnt == $past(fail_cnt) - 1'b1);

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !diag_entry |=> (fail_cnt == $past(fail_cnt) ||
                     fail_cnt == $past(fail_cnt) + 1'b1 ||
                     fail_cnt == $past(fail_cnt) - 1'b1));

  // R6
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reset_req |-> ($past(rst_en) && $past(fail_cnt) == CNT_MAX));

  // R8
  req_restart_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reset_req |-> win_phase == WIN_CLOSED);

  // R9
  diag_init_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    diag_entry |=> fail_cnt == INIT_V);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cfg_wr |=> ($stable(closed_len) && $stable(open_len)));

endmodule

bind wdt_window_guard wdt_window_guard_chk #(
  .CLOSED_W(CLOSED_W),
  .OPEN_W  (OPEN_W),
  .CNT_W   (CNT_W),
  .CNT_INIT(CNT_INIT)
) chk_i (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .svc_strobe(svc_strobe),
  .diag_entry(diag_entry),
  .rst_en    (rst_en),
  .cfg_wr    (cfg_wr),
  .win_phase (win_phase),
  .closed_len(closed_len),
  .open_len  (open_len),
  .fail_cnt  (fail_cnt),
  .reset_req (reset_req)
);

// File: tb/wdt_window_guard_tb.sv
`timescale 1ns/1ps
module wdt_window_guard_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, svc_strobe, cfg_wr, rst_en, diag_entry;
  logic [6:0] cfg_closed_len;
  logic [4:0] cfg_open_len;
  logic [2:0] fail_cnt;
  logic       reset_req;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  wdt_window_guard dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .svc_strobe    (svc_strobe),
    .cfg_wr        (cfg_wr),
    .cfg_closed_len(cfg_closed_len),
    .cfg_open_len  (cfg_open_len),
    .rst_en        (rst_en),
    .diag_entry    (diag_entry),
    .fail_cnt      (fail_cnt),
    .reset_req     (reset_req)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      for (int i = 0; i < n; i++) begin
        @(negedge clk) tick_en = 1'b1;
      end
      @(negedge clk) tick_en = 1'b0;
    end
  endtask

  task automatic svc();
    @(negedge clk) svc_strobe = 1'b1;
    @(negedge clk) svc_strobe = 1'b0;
  endtask

  task automatic diag();
    @(negedge clk) diag_entry = 1'b1;
    @(negedge clk) diag_entry = 1'b0;
  endtask

  task automatic cfg(input int c, input int o);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_closed_len = 7'(c); cfg_open_len = 5'(o);
    @(negedge clk) cfg_wr = 1'b0;
  endtask

  task automatic por();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 0; svc_strobe = 0; cfg_wr = 0; rst_en = 0; diag_entry = 0;
    cfg_closed_len = '0; cfg_open_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 cnt", fail_cnt, 5);
    check("R1 req", reset_req, 0);

    // R2 R3 R4 sweep of service position and timeout over small windows
    for (int c = 0; c <= 4; c++) begin
      for (int o = 0; o <= 3; o++) begin
        int c1;
        c1 = (c == 0) ? 1 : c;
        cfg(c, o);
        for (int p = 0; p < c1 + o + 1; p++) begin
          diag();
          ticks(p);
          svc();
          check((p < c1) ? "R2 closed svc" : "R3 open svc", fail_cnt, (p < c1) ? 6 : 4);
        end
        diag();
        ticks(c1 + o);
        check("R4 before timeout", fail_cnt, 5);
        ticks(1);
        check("R4 timeout", fail_cnt, 6);
      end
    end

    // R3 good service restarts the sequence
    cfg(3, 2);
    diag(); ticks(3); svc();
    check("R3 good", fail_cnt, 4);
    ticks(2); svc();
    check("R3 restarted closed", fail_cnt, 5);

    // R5 saturation with rst_en low; R6 no request without enable
    cfg(2, 1);
    rst_en = 1'b0;
    diag();
    for (int k = 0; k < 4; k++) begin
      svc();
      check("R6 no req when disabled", reset_req, 0);
      check("R5 saturate up", fail_cnt, (k == 0) ? 6 : 7);
    end

    // R7 enable while at 7
    @(negedge clk) rst_en = 1'b1;
    @(negedge clk);
    check("R7 req on enable", reset_req, 1);
    @(negedge clk);
    check("R7 single pulse", reset_req, 0);
    check("R7 cnt", fail_cnt, 7);

    // R6 bad event at 7 with enable
    svc();
    check("R6 req", reset_req, 1);
    check("R6 cnt held", fail_cnt, 7);
    @(negedge clk);
    check("R6 pulse width", reset_req, 0);

    // R5 decrement with rst_en high, floor at 0
    diag();
    for (int k = 0; k < 6; k++) begin
      ticks(2); svc();
      check("R5 floor down", fail_cnt, (k < 5) ? 4 - k : 0);
    end
    // R7 enable edge below 7 gives nothing
    @(negedge clk) rst_en = 1'b0;
    @(negedge clk) rst_en = 1'b1;
    @(negedge clk);
    check("R7 no req below max", reset_req, 0);

    // R8 timer restarts after a request
    rst_en = 1'b0;
    cfg(3, 2);
    diag(); svc(); svc();
    check("R8 setup", fail_cnt, 7);
    @(negedge clk) rst_en = 1'b1;
    @(negedge clk);
    check("R8 enable req", reset_req, 1);
    ticks(2); svc();
    check("R8 req", reset_req, 1);
    ticks(2); svc();
    check("R8 restarted closed", reset_req, 1);
    check("R8 cnt", fail_cnt, 7);

    // R9 diag overrides service and restarts the timer
    rst_en = 1'b0;
    @(negedge clk);
    diag_entry = 1'b1; svc_strobe = 1'b1;
    @(negedge clk);
    diag_entry = 1'b0; svc_strobe = 1'b0;
    check("R9 override", fail_cnt, 5);
    ticks(2); diag(); ticks(2); svc();
    check("R9 restart", fail_cnt, 6);

    // R11 service and tick in the same cycle
    cfg(2, 3);
    diag(); ticks(1);
    @(negedge clk) begin tick_en = 1'b1; svc_strobe = 1'b1; end
    @(negedge clk) begin tick_en = 1'b0; svc_strobe = 1'b0; end
    check("R11 judged closed", fail_cnt, 6);
    svc();
    check("R11 tick advanced", fail_cnt, 5);

    // R10 config survives request and diag
    cfg(2, 1);
    rst_en = 1'b1;
    diag(); svc(); svc(); svc();
    check("R10 req", reset_req, 1);
    rst_en = 1'b0;
    diag(); ticks(1); svc();
    check("R10 kept closed", fail_cnt, 6);
    diag(); ticks(2); svc();
    check("R10 kept open", fail_cnt, 4);

    // R1 R10 power-on reset restores defaults
    por();
    check("R1 cnt after por", fail_cnt, 5);
    check("R1 req after por", reset_req, 0);
    ticks(126); svc();
    check("R10 default closed", fail_cnt, 6);
    diag(); ticks(127); svc();
    check("R10 default open", fail_cnt, 4);
    diag(); ticks(158);
    check("R10 default before timeout", fail_cnt, 5);
    ticks(1);
    check("R10 default timeout", fail_cnt, 6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule